// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This unit sits beside the decode stage of an in-order five-stage pipeline. Each cycle it takes the two source register numbers of the instruction in decode. It compares them with the destination register and write-enable of the instructions now in execute, memory and writeback. For each source it returns a 2-bit bypass code, which the execute-stage operand muxes use once the instruction moves into execute. It also returns a single interlock request that freezes fetch and decode and inserts a bubble.

The register file writes in the first half of the cycle and is read in the second half. Because of this, a producer in writeback needs no bypass path, and only the execute/memory and memory/writeback pipeline registers feed the muxes. When more than one stage holds a pending write to the same register, the youngest producer wins. A load's data exists only after the memory stage, so a load in execute that feeds a decode operand cannot be bypassed. It stalls the pipeline for one cycle instead.

The unit is purely combinational. Every output follows the current inputs within the same cycle, so after an interlock the codes are worked out again against the advanced pipeline. The clock and reset are used only to time the built-in property checks.

Top module: `hazfwd_unit`

## Requirements
- R1: A source that matches the execute-stage destination, with the execute write-enable set and the execute load flag clear, gets code 01 (bypass from the execute/memory register).
- R2: A source that matches only the memory-stage destination, with the memory write-enable set, gets code 10 (bypass from the memory/writeback register). This holds whether that instruction is a load or not.
- R3: When both the execute and memory stages hold an enabled write to the same source register, the code is 01, because the execute stage is the younger producer.
- R4: A source whose only match is the writeback stage gets code 00 (register file), since the write lands before the read.
- R5: A stage whose write-enable is low never produces a match, whatever its destination number.
- R6: Source register 0 always gets code 00 and never causes an interlock, even when a stage writes register 0.
- R7: The two sources are resolved independently, so in one cycle they may get different codes.
- R8: If the execute stage holds a load (write-enable and load flag both set, destination non-zero) whose destination equals either source, stall is 1 and both codes are 00.
- R9: stall is 0 whenever no source matches a load in execute, including when a load in execute targets an unrelated register.
- R10: Outputs depend only on the inputs of the same cycle. When a stalled load has moved on to the memory stage, the matching source gets code 10 and stall drops to 0.
- R11: Code 11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to sample the built-in property checks |
| rst_n | input | 1 | Active-low reset; disables the property checks |
| dec_rs | input | REG_W | First source register number of the instruction in decode |
| dec_rt | input | REG_W | Second source register number of the instruction in decode |
| ex_dst | input | REG_W | Destination register of the instruction in execute |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | REG_W | Destination register of the instruction in memory |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | REG_W | Destination register of the instruction in writeback |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| fwd_rs | output | 2 | Bypass code for the first source: 00 register file, 01 execute/memory, 10 memory/writeback |
| fwd_rt | output | 2 | Bypass code for the second source, same encoding |
| stall | output | 1 | Load-use interlock request |

## Verification
The bench targets priority when execute and memory both write the same register. A design that let the older stage win would hand the execute stage a stale value. It checks register 0 against stages that write register 0, where a missing guard would bypass a discarded value or stall for nothing. It drives a load in execute against each source in turn, and against a non-matching register, to expose a missing or spurious interlock and codes that are not cleared during it. A sweep of every register number through the memory stage, and a writeback-only case, catch comparator slicing errors and a bypass wrongly taken from writeback.

// File: rtl/hazfwd_pkg.sv
package hazfwd_pkg;

    // stage slots of the pending-write view, youngest first
    localparam int STG_EX  = 0;
    localparam int STG_MEM = 1;
    localparam int STG_WB  = 2;
    localparam int NSTAGE  = 3;

    // number of decode source operands
    localparam int NSRC = 2;

    typedef enum logic [1:0] {
        FWD_REGFILE = 2'b00,
        FWD_EXMEM   = 2'b01,
        FWD_MEMWB   = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        fwd_sel_e sel;
        logic     load_hit;
    } opnd_res_t;

endpackage

// File: rtl/hazfwd_cmp.sv
module hazfwd_cmp #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    input  logic             wr,
    output logic             hit
);

    // register 0 is hard-wired, so a write to it is never pending
    always_comb begin
        hit = wr && (dst == src) && (src != '0);
    end

endmodule

// File: rtl/hazfwd_operand.sv
module hazfwd_operand
    import hazfwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] stg_dst [NSTAGE],
    input  logic [NSTAGE-1:0] stg_wr,
    input  logic             ex_load,
    output opnd_res_t        res
);

    logic [NSTAGE-1:0] hit;
    opnd_res_t         res_d;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_cmp
        hazfwd_cmp #(.REG_W(REG_W)) u_cmp (
            .src (src),
            .dst (stg_dst[g]),
            .wr  (stg_wr[g]),
            .hit (hit[g])
        );
    end

    // youngest producer first; writeback needs no path
    always_comb begin
        res_d.sel      = FWD_REGFILE;
        res_d.load_hit = 1'b0;
        if (hit[STG_EX]) begin
            if (ex_load) begin
                res_d.load_hit = 1'b1;
            end else begin
                res_d.sel = FWD_EXMEM;
            end
        end else if (hit[STG_MEM]) begin
            res_d.sel = FWD_MEMWB;
        end
    end

    assign res = res_d;

    // R4: a producer seen only in writeback is read from the register file
    a_r4_wb_only_regfile: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[STG_WB] && !hit[STG_EX] && !hit[STG_MEM]) |-> (res.sel == FWD_REGFILE));

    // R3: an execute-stage producer always beats the memory stage
    a_r3_youngest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[STG_EX] && hit[STG_MEM] && !ex_load) |-> (res.sel == FWD_EXMEM));

    // R6: register 0 never bypasses nor interlocks
    a_r6_zero_src_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (res.sel == FWD_REGFILE && !res.load_hit));

endmodule

// File: rtl/hazfwd_unit.sv
module hazfwd_unit
    import hazfwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] dec_rs,
    input  logic [REG_W-1:0] dec_rt,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wr,
    input  logic             ex_load,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wr,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wr,
    output logic [1:0]       fwd_rs,
    output logic [1:0]       fwd_rt,
    output logic             stall
);

    typedef struct packed {
        logic [1:0] rs_sel;
        logic [1:0] rt_sel;
        logic       stall;
    } out_t;

    logic [REG_W-1:0]  src      [NSRC];
    logic [REG_W-1:0]  stg_dst  [NSTAGE];
    logic [NSTAGE-1:0] stg_wr;
    opnd_res_t         opnd_res [NSRC];
    out_t              out_d;

    always_comb begin
        src[0]           = dec_rs;
        src[1]           = dec_rt;
        stg_dst[STG_EX]  = ex_dst;
        stg_dst[STG_MEM] = mem_dst;
        stg_dst[STG_WB]  = wb_dst;
        stg_wr           = '0;
        stg_wr[STG_EX]   = ex_wr;
        stg_wr[STG_MEM]  = mem_wr;
        stg_wr[STG_WB]   = wb_wr;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        hazfwd_operand #(.REG_W(REG_W)) u_opnd (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (src[s]),
            .stg_dst (stg_dst),
            .stg_wr  (stg_wr),
            .ex_load (ex_load),
            .res     (opnd_res[s])
        );
    end

    // an interlock sends a bubble, so both codes fall back to the file
    always_comb begin
        out_d.stall  = opnd_res[0].load_hit || opnd_res[1].load_hit;
        out_d.rs_sel = out_d.stall ? FWD_REGFILE : opnd_res[0].sel;
        out_d.rt_sel = out_d.stall ? FWD_REGFILE : opnd_res[1].sel;
    end

    assign fwd_rs = out_d.rs_sel;
    assign fwd_rt = out_d.rt_sel;
    assign stall  = out_d.stall;

    // R8: load in execute feeding a source must interlock with quiet codes
    a_r8_load_use_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_wr && ex_load && ex_dst != '0 && (ex_dst == dec_rs || ex_dst == dec_rt))
        |-> (stall && fwd_rs == 2'b00 && fwd_rt == 2'b00));

    // R9: no load in execute means no interlock
    a_r9_no_spurious_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !(ex_wr && ex_load) |-> !stall);

    // R11: the unused code never appears
    a_r11_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_rs != 2'b11) && (fwd_rt != 2'b11));

    // R5: with every write-enable low nothing is bypassed
    a_r5_idle_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_wr && !mem_wr) |-> (fwd_rs == 2'b00 && fwd_rt == 2'b00 && !stall));

endmodule

// File: tb/hazfwd_unit_tb.sv
module hazfwd_unit_tb;

    localparam int REG_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [REG_W-1:0] dec_rs = '0, dec_rt = '0, ex_dst = '0, mem_dst = '0, wb_dst = '0;
    logic             ex_wr = 1'b0, ex_load = 1'b0, mem_wr = 1'b0, wb_wr = 1'b0;
    logic [1:0]       fwd_rs, fwd_rt;
    logic             stall;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    hazfwd_unit #(.REG_W(REG_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .dec_rs(dec_rs), .dec_rt(dec_rt),
        .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
        .mem_dst(mem_dst), .mem_wr(mem_wr),
        .wb_dst(wb_dst), .wb_wr(wb_wr),
        .fwd_rs(fwd_rs), .fwd_rt(fwd_rt), .stall(stall)
    );

    // rs rt | exd exw exl | memd memw | wbd wbw | exp rs rt stall | req
    typedef struct packed {
        logic [4:0] rs, rt, exd;
        logic       exw, exl;
        logic [4:0] memd;
        logic       memw;
        logic [4:0] wbd;
        logic       wbw;
        logic [1:0] ers, ert;
        logic       est;
        logic [7:0] req;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{5'd3, 5'd9, 5'd3, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 2'b01, 2'b00, 1'b0, 8'd1},   // R1
        '{5'd9, 5'd4, 5'd0, 1'b0, 1'b0, 5'd4, 1'b1, 5'd0, 1'b0, 2'b00, 2'b10, 1'b0, 8'd2},   // R2
        '{5'd6, 5'd1, 5'd2, 1'b1, 1'b0, 5'd6, 1'b1, 5'd0, 1'b0, 2'b10, 2'b00, 1'b0, 8'd2},   // R2 non-load ex elsewhere
        '{5'd7, 5'd7, 5'd7, 1'b1, 1'b0, 5'd7, 1'b1, 5'd7, 1'b1, 2'b01, 2'b01, 1'b0, 8'd3},   // R3
        '{5'd8, 5'd2, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd8, 1'b1, 2'b00, 2'b00, 1'b0, 8'd4},   // R4
        '{5'd5, 5'd5, 5'd5, 1'b0, 1'b1, 5'd5, 1'b0, 5'd5, 1'b0, 2'b00, 2'b00, 1'b0, 8'd5},   // R5
        '{5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 2'b00, 2'b00, 1'b0, 8'd6},   // R6
        '{5'd0, 5'd12, 5'd0, 1'b1, 1'b0, 5'd12, 1'b1, 5'd0, 1'b0, 2'b00, 2'b10, 1'b0, 8'd6}, // R6 mixed
        '{5'd10, 5'd11, 5'd10, 1'b1, 1'b0, 5'd11, 1'b1, 5'd0, 1'b0, 2'b01, 2'b10, 1'b0, 8'd7}, // R7
        '{5'd13, 5'd14, 5'd14, 1'b1, 1'b1, 5'd13, 1'b1, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1, 8'd8}, // R8 via rt
        '{5'd15, 5'd16, 5'd17, 1'b1, 1'b1, 5'd15, 1'b1, 5'd0, 1'b0, 2'b10, 2'b00, 1'b0, 8'd9}, // R9
        '{5'd18, 5'd19, 5'd18, 1'b1, 1'b0, 5'd18, 1'b1, 5'd0, 1'b0, 2'b01, 2'b00, 1'b0, 8'd11} // R11 legal codes
    };

    task automatic check(input int req, input logic [1:0] ers, input logic [1:0] ert,
                         input logic est);
        checks++;
        if (fwd_rs !== ers || fwd_rt !== ert || stall !== est) begin
            failures++;
            $display("FAIL R%0d: got rs=%b rt=%b stall=%b expected rs=%b rt=%b stall=%b",
                     req, fwd_rs, fwd_rt, stall, ers, ert, est);
        end
    endtask

    task automatic drive(input logic [4:0] rs, input logic [4:0] rt,
                         input logic [4:0] exd, input logic exw, input logic exl,
                         input logic [4:0] memd, input logic memw,
                         input logic [4:0] wbd, input logic wbw);
        @(negedge clk);
        dec_rs = rs; dec_rt = rt; ex_dst = exd; ex_wr = exw; ex_load = exl;
        mem_dst = memd; mem_wr = memw; wb_dst = wbd; wb_wr = wbw;
        #2;
    endtask

    initial begin
        // reset state: idle pipe gives register-file codes and no stall
        repeat (2) @(negedge clk);
        #2;
        check(5, 2'b00, 2'b00, 1'b0);  // R5 reset/idle
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].rs, VECS[i].rt, VECS[i].exd, VECS[i].exw, VECS[i].exl,
                  VECS[i].memd, VECS[i].memw, VECS[i].wbd, VECS[i].wbw);
            check(int'(VECS[i].req), VECS[i].ers, VECS[i].ert, VECS[i].est);
        end

        // R8 via rs, with rt bypassable from memory: codes still cleared
        drive(5'd20, 5'd21, 5'd20, 1'b1, 1'b1, 5'd21, 1'b1, 5'd0, 1'b0);
        check(8, 2'b00, 2'b00, 1'b1);
        // R10: next cycle the load has moved into memory
        drive(5'd20, 5'd21, 5'd0, 1'b0, 1'b0, 5'd20, 1'b1, 5'd21, 1'b1);
        check(10, 2'b10, 2'b00, 1'b0);
        // R6: load in execute writing register 0 against source 0
        drive(5'd0, 5'd3, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        check(6, 2'b00, 2'b00, 1'b0);
        // R9: load in execute with write-enable low
        drive(5'd22, 5'd22, 5'd22, 1'b0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        check(9, 2'b00, 2'b00, 1'b0);

        // R2 / R7 sweep over every non-zero register through the memory stage
        for (int r = 1; r < 32; r++) begin
            drive(5'(r), 5'(r ^ 1), 5'd0, 1'b0, 1'b0, 5'(r), 1'b1, 5'(r ^ 1), 1'b1);
            check(2, 2'b10, (r == 1) ? 2'b00 : 2'b00, 1'b0);
        end
        // R1 sweep through the execute stage on rt
        for (int r = 1; r < 32; r++) begin
            drive(5'd0, 5'(r), 5'(r), 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
            check(1, 2'b00, 2'b01, 1'b0);
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule